// File: doc/BRIEF.md
# Audio Sample Capture to DMA Bridge

This block paces a sampling A/D converter and hands its samples to a DMA engine. A sample-period timer, set from a 3-bit rate code and a fixed system clock frequency, issues one conversion request per sample period while capture is enabled. The converter answers with an acknowledge and a 12-bit sample.

The sample lands in a holding stage. It then moves to a staging register, which drives the DMA write request. Each stage has its own valid flag, and the flags step through a fixed sequence. A sticky status bit records each completed receive. A second one records data loss, meaning the holding stage was still full when the next conversion tick came. A third records a page-boundary event from the DMA side, and this bit also pauses capture until it is cleared.

Before the first request, the block waits for the converter reference to settle after it is switched on. Software uses the block by setting the rate code, turning the reference on, raising the capture enable and serving the DMA requests. It clears status bits by write-one-to-clear pulses.

Top module: `audio_capture_dma`

## Requirements
- R1: After reset, conv_req, dma_req, hold_valid, stage_valid, irq and all irq_status bits are 0.
- R2: While capture runs, conv_req is a one-cycle pulse repeating every CLK_HZ/rate cycles. Rate codes 0, 1, 2 and 3 select 44100, 22050, 11025 and 8000 samples/s, and codes 4 to 7 behave as code 3. With the default 1 MHz clock the spacings are 22, 45, 90 and 125 cycles.
- R3: When vref_on and capture_en rise in the same cycle, the first conv_req comes SETTLE_CYC + period cycles later (5 + period by default). When the reference has already settled, the first conv_req comes one period after enable.
- R4: An adc_ack while capture is enabled stores adc_data and sets hold_valid. stage_valid stays 0 until the move.
- R5: In the cycle after the capture, if the staging side is free, the sample moves. stage_valid becomes 1, hold_valid becomes 0, dma_req rises with dma_data equal to the sample, and irq_status[0] (receive complete) is set.
- R6: A dma_ack while dma_req is high drops dma_req and stage_valid, which leaves both valid flags at 0.
- R7: A conversion tick that finds hold_valid still 1 sets irq_status[1] (data lost).
- R8: A page_hit pulse sets irq_status[2]. No conv_req is issued while that bit is set. After it is cleared, requests resume one period later.
- R9: Status bits are sticky and are cleared by 1s on irq_clr. irq is high exactly when a status bit and its irq_en bit are both 1.
- R10: Dropping capture_en stops conv_req at once and clears hold_valid and stage_valid. A dma_req already raised stays high until its dma_ack. adc_ack is ignored while capture is disabled.
- R11: Dropping vref_on restarts the settling interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, frequency CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| capture_en | input | 1 | Capture enable |
| vref_on | input | 1 | Converter reference switched on |
| rate_code | input | 3 | Sample rate select |
| conv_req | output | 1 | Conversion request pulse |
| adc_ack | input | 1 | Converter acknowledge with sample |
| adc_data | input | 12 | Converter sample |
| dma_req | output | 1 | DMA write request |
| dma_ack | input | 1 | DMA transfer done |
| dma_data | output | 12 | Word to write to memory |
| page_hit | input | 1 | Page-boundary pulse from DMA side |
| irq_en | input | 3 | Interrupt enable per status bit |
| irq_clr | input | 3 | Write-one-to-clear pulses for status |
| irq_status | output | 3 | Sticky status: [0] receive, [1] lost, [2] page |
| irq | output | 1 | Interrupt request |
| hold_valid | output | 1 | Holding stage valid |
| stage_valid | output | 1 | DMA staging register valid |

## Verification
The flag sequence is driven by one sample answered promptly, with the DMA acknowledged right away. This separates the hold step, the move step and the retirement step one cycle at a time. A second pattern leaves the DMA request unanswered while two samples arrive. Only a correct overrun test against the holding stage flags loss on the following tick, while a correct capture of the first sample does not. Request timing is measured three ways: reference and enable raised together, enable raised with the reference already settled, and after a page pause. Together these tell the settle delay, the period and the pause restart apart. All eight rate codes are stepped so that each code's spacing, including the fallback codes, is seen.

// File: rtl/capture_pkg.sv
package capture_pkg;

  localparam int SAMPLE_W = 12;
  localparam int IRQ_W    = 3;
  localparam int IRQ_RX   = 0;
  localparam int IRQ_LOST = 1;
  localparam int IRQ_PAGE = 2;

  // sample rate in samples/s for a rate code; unused codes fall to the lowest rate
  function automatic int unsigned rate_hz(logic [2:0] code);
    case (code)
      3'd0:    return 44100;
      3'd1:    return 22050;
      3'd2:    return 11025;
      default: return 8000;
    endcase
  endfunction

  // clock cycles per sample period, never below 2
  function automatic int unsigned period_cycles(int unsigned clk_hz, logic [2:0] code);
    int unsigned p;
    p = clk_hz / rate_hz(code);
    return (p < 2) ? 2 : p;
  endfunction

  // reference settling interval in clock cycles, at least 1
  function automatic int unsigned settle_cycles(int unsigned clk_hz, int unsigned settle_ns);
    longint unsigned c;
    c = (longint'(clk_hz) * longint'(settle_ns)) / 64'd1_000_000_000;
    return (c < 1) ? 1 : int'(c);
  endfunction

endpackage

// File: rtl/rate_timer.sv
module rate_timer
  import capture_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 1_000_000,
  parameter int unsigned SETTLE_CYC = 5,
  parameter int          CNT_W      = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vref_on,
  input  logic       run_req,
  input  logic [2:0] rate_code,
  output logic       settled,
  output logic       tick
);

  localparam int SW = $clog2(SETTLE_CYC + 1);

  logic [SW-1:0]    settle_cnt;
  logic [CNT_W-1:0] per_cnt;
  logic [CNT_W-1:0] div_w;
  logic             run;

  assign div_w   = CNT_W'(period_cycles(CLK_HZ, rate_code));
  assign settled = (settle_cnt == SW'(SETTLE_CYC));
  assign run     = run_req && settled;
  assign tick    = run && (per_cnt >= div_w - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_cnt <= '0;
    end else if (!vref_on) begin
      settle_cnt <= '0;
    end else if (!settled) begin
      settle_cnt <= settle_cnt + SW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_cnt <= '0;
    end else if (!run || tick) begin
      per_cnt <= '0;
    end else begin
      per_cnt <= per_cnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/sample_pipe.sv
module sample_pipe
  import capture_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                tick,
  input  logic                adc_ack,
  input  logic [SAMPLE_W-1:0] adc_data,
  input  logic                dma_ack,
  output logic                hold_valid,
  output logic                stage_valid,
  output logic                dma_req,
  output logic [SAMPLE_W-1:0] dma_data,
  output logic                move_ev,
  output logic                lost_ev
);

  logic [SAMPLE_W-1:0] hold_q;
  logic                take;

  assign take    = en && adc_ack;
  assign move_ev = en && hold_valid && !stage_valid && !dma_req;
  assign lost_ev = tick && hold_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q     <= '0;
      hold_valid <= 1'b0;
    end else if (!en) begin
      hold_valid <= 1'b0;
    end else if (take) begin
      hold_q     <= adc_data;
      hold_valid <= 1'b1;
    end else if (move_ev) begin
      hold_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_valid <= 1'b0;
      dma_data    <= '0;
    end else if (!en) begin
      stage_valid <= 1'b0;
    end else if (move_ev) begin
      stage_valid <= 1'b1;
      dma_data    <= hold_q;
    end else if (dma_ack && dma_req) begin
      stage_valid <= 1'b0;
    end
  end

  // the handshake outlives a disable so an accepted request always completes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_req <= 1'b0;
    end else if (move_ev) begin
      dma_req <= 1'b1;
    end else if (dma_ack) begin
      dma_req <= 1'b0;
    end
  end

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import capture_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_W-1:0] set_ev,
  input  logic [IRQ_W-1:0] clr,
  input  logic [IRQ_W-1:0] en,
  output logic [IRQ_W-1:0] status,
  output logic             irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
    end else begin
      status <= (status & ~clr) | set_ev;
    end
  end

  assign irq = |(status & en);

endmodule

// File: rtl/audio_capture_dma.sv
module audio_capture_dma
  import capture_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 1_000_000,
  parameter int unsigned SETTLE_NS = 5000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                capture_en,
  input  logic                vref_on,
  input  logic [2:0]          rate_code,
  output logic                conv_req,
  input  logic                adc_ack,
  input  logic [SAMPLE_W-1:0] adc_data,
  output logic                dma_req,
  input  logic                dma_ack,
  output logic [SAMPLE_W-1:0] dma_data,
  input  logic                page_hit,
  input  logic [IRQ_W-1:0]    irq_en,
  input  logic [IRQ_W-1:0]    irq_clr,
  output logic [IRQ_W-1:0]    irq_status,
  output logic                irq,
  output logic                hold_valid,
  output logic                stage_valid
);

  localparam int unsigned SETTLE_CYC = settle_cycles(CLK_HZ, SETTLE_NS);
  localparam int unsigned MAX_PER    = period_cycles(CLK_HZ, 3'd7);
  localparam int          CNT_W      = $clog2(MAX_PER + 1);

  logic             tick_w;
  logic             settled_w;
  logic             paused_w;
  logic             move_w;
  logic             lost_w;
  logic [IRQ_W-1:0] set_w;

  assign paused_w = irq_status[IRQ_PAGE];

  rate_timer #(
    .CLK_HZ    (CLK_HZ),
    .SETTLE_CYC(SETTLE_CYC),
    .CNT_W     (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .vref_on  (vref_on),
    .run_req  (capture_en && !paused_w),
    .rate_code(rate_code),
    .settled  (settled_w),
    .tick     (tick_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) conv_req <= 1'b0;
    else        conv_req <= tick_w;
  end

  sample_pipe u_pipe (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (capture_en),
    .tick       (tick_w),
    .adc_ack    (adc_ack),
    .adc_data   (adc_data),
    .dma_ack    (dma_ack),
    .hold_valid (hold_valid),
    .stage_valid(stage_valid),
    .dma_req    (dma_req),
    .dma_data   (dma_data),
    .move_ev    (move_w),
    .lost_ev    (lost_w)
  );

  always_comb begin
    set_w           = '0;
    set_w[IRQ_RX]   = move_w;
    set_w[IRQ_LOST] = lost_w;
    set_w[IRQ_PAGE] = page_hit;
  end

  irq_ctrl u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .set_ev(set_w),
    .clr   (irq_clr),
    .en    (irq_en),
    .status(irq_status),
    .irq   (irq)
  );

endmodule

// File: rtl/audio_capture_chk.sv
module audio_capture_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       capture_en,
  input logic       tick,
  input logic       conv_req,
  input logic       adc_ack,
  input logic       dma_req,
  input logic       dma_ack,
  input logic       hold_valid,
  input logic       stage_valid,
  input logic [2:0] irq_status,
  input logic [2:0] irq_clr
);

  // R2
  conv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |=> !conv_req);

  // R4
  capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_en && adc_ack) |=> hold_valid);

  // R5
  stage_from_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stage_valid) |-> ($past(hold_valid) && irq_status[0]));

  // R6
  dma_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && dma_ack) |=> (!dma_req && !stage_valid));

  // R7
  overrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && hold_valid) |=> irq_status[1]);

  // R8
  page_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_status[2] |-> !tick);

  // R10
  disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_en |=> (!hold_valid && !stage_valid && !conv_req));

  // R9
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_status[0] && !irq_clr[0]) |=> irq_status[0]);

endmodule

bind audio_capture_dma audio_capture_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .capture_en (capture_en),
  .tick       (tick_w),
  .conv_req   (conv_req),
  .adc_ack    (adc_ack),
  .dma_req    (dma_req),
  .dma_ack    (dma_ack),
  .hold_valid (hold_valid),
  .stage_valid(stage_valid),
  .irq_status (irq_status),
  .irq_clr    (irq_clr)
);

// File: tb/test_audio_capture_dma.sv
module test_audio_capture_dma;

  localparam int CLK_PERIOD = 10;
  localparam int SYS_HZ     = 1_000_000;
  localparam int SETTLE     = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        capture_en = 1'b0;
  logic        vref_on = 1'b0;
  logic [2:0]  rate_code = 3'd0;
  logic        conv_req;
  logic        adc_ack = 1'b0;
  logic [11:0] adc_data = '0;
  logic        dma_req;
  logic        dma_ack = 1'b0;
  logic [11:0] dma_data;
  logic        page_hit = 1'b0;
  logic [2:0]  irq_en = 3'b000;
  logic [2:0]  irq_clr = 3'b000;
  logic [2:0]  irq_status;
  logic        irq;
  logic        hold_valid;
  logic        stage_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  audio_capture_dma i_audio_capture_dma (
    .clk(clk), .rst_n(rst_n), .capture_en(capture_en), .vref_on(vref_on),
    .rate_code(rate_code), .conv_req(conv_req), .adc_ack(adc_ack),
    .adc_data(adc_data), .dma_req(dma_req), .dma_ack(dma_ack),
    .dma_data(dma_data), .page_hit(page_hit), .irq_en(irq_en),
    .irq_clr(irq_clr), .irq_status(irq_status), .irq(irq),
    .hold_valid(hold_valid), .stage_valid(stage_valid)
  );

  function automatic int spacing(int code);
    int r;
    if (code == 0)      r = 44100;
    else if (code == 1) r = 22050;
    else if (code == 2) r = 11025;
    else                r = 8000;
    return SYS_HZ / r;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // counts rising edges from the current falling edge until conv_req is seen
  task automatic wait_req(output int n);
    n = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      n++;
      if (conv_req) return;
    end
    n = -1;
  endtask

  task automatic clear_all();
    irq_clr = 3'b111;
    @(negedge clk);
    irq_clr = 3'b000;
  endtask

  task automatic t_reset();
    chk("R1 conv_req", conv_req, 0);
    chk("R1 dma_req", dma_req, 0);
    chk("R1 flags", {hold_valid, stage_valid}, 0);
    chk("R1 status", irq_status, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_settle();
    int n;
    rate_code = 3'd0;
    vref_on = 1'b1;
    capture_en = 1'b1;
    wait_req(n);
    chk("R3 first request after settle", n, SETTLE + spacing(0));
  endtask

  task automatic t_rates();
    int n;
    for (int c = 0; c < 8; c++) begin
      wait_req(n);
      rate_code = 3'(c);
      wait_req(n);
      chk($sformatf("R2 spacing code %0d", c), n, spacing(c));
      wait_req(n);
      chk($sformatf("R2 repeat code %0d", c), n, spacing(c));
    end
    rate_code = 3'd0;
    wait_req(n);
  endtask

  task automatic t_settled_enable();
    int n;
    capture_en = 1'b0;
    @(negedge clk);
    capture_en = 1'b1;
    wait_req(n);
    chk("R3 settled enable", n, spacing(0));
  endtask

  task automatic t_vref_drop();
    int n;
    vref_on = 1'b0;
    @(negedge clk);
    vref_on = 1'b1;
    wait_req(n);
    chk("R11 settle restarts", n, SETTLE + spacing(0));
  endtask

  task automatic t_flow();
    int n;
    clear_all();
    wait_req(n);
    adc_ack = 1'b1;
    adc_data = 12'hA5C;
    @(negedge clk);
    adc_ack = 1'b0;
    chk("R4 hold_valid", hold_valid, 1);
    chk("R4 stage_valid", stage_valid, 0);
    @(negedge clk);
    chk("R5 stage_valid", stage_valid, 1);
    chk("R5 hold_valid", hold_valid, 0);
    chk("R5 dma_req", dma_req, 1);
    chk("R5 dma_data", dma_data, 12'hA5C);
    chk("R5 rx status", irq_status[0], 1);
    dma_ack = 1'b1;
    @(negedge clk);
    dma_ack = 1'b0;
    chk("R6 dma_req", dma_req, 0);
    chk("R6 flags", {hold_valid, stage_valid}, 0);
  endtask

  task automatic t_overrun_irq();
    int n;
    clear_all();
    wait_req(n);
    adc_ack = 1'b1;
    adc_data = 12'h123;
    @(negedge clk);
    adc_ack = 1'b0;
    @(negedge clk);
    chk("R5 staged first", dma_data, 12'h123);
    wait_req(n);
    chk("R7 no loss yet", irq_status[1], 0);
    adc_ack = 1'b1;
    adc_data = 12'h456;
    @(negedge clk);
    adc_ack = 1'b0;
    chk("R7 hold waits", {hold_valid, stage_valid}, 3);
    wait_req(n);
    chk("R7 loss flagged", irq_status[1], 1);
    irq_en = 3'b100;
    @(negedge clk);
    chk("R9 masked irq", irq, 0);
    irq_en = 3'b010;
    @(negedge clk);
    chk("R9 enabled irq", irq, 1);
    irq_clr = 3'b010;
    @(negedge clk);
    irq_clr = 3'b000;
    chk("R9 w1c status", irq_status, 3'b001);
    chk("R9 irq after clear", irq, 0);
    dma_ack = 1'b1;
    @(negedge clk);
    dma_ack = 1'b0;
    @(negedge clk);
    chk("R6 second sample moves", dma_data, 12'h456);
    dma_ack = 1'b1;
    @(negedge clk);
    dma_ack = 1'b0;
    irq_en = 3'b000;
    clear_all();
  endtask

  task automatic t_page();
    int n;
    int seen;
    page_hit = 1'b1;
    @(negedge clk);
    page_hit = 1'b0;
    chk("R8 page status", irq_status[2], 1);
    seen = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      seen += int'(conv_req);
    end
    chk("R8 paused requests", seen, 0);
    irq_clr = 3'b100;
    @(negedge clk);
    irq_clr = 3'b000;
    wait_req(n);
    chk("R8 resume after clear", n, spacing(0));
  endtask

  task automatic t_disable();
    int n;
    int seen;
    wait_req(n);
    adc_ack = 1'b1;
    adc_data = 12'h7E1;
    @(negedge clk);
    adc_ack = 1'b0;
    @(negedge clk);
    capture_en = 1'b0;
    @(negedge clk);
    chk("R10 flags cleared", {hold_valid, stage_valid}, 0);
    chk("R10 dma_req held", dma_req, 1);
    adc_ack = 1'b1;
    adc_data = 12'h001;
    @(negedge clk);
    adc_ack = 1'b0;
    chk("R10 ack ignored", hold_valid, 0);
    dma_ack = 1'b1;
    @(negedge clk);
    dma_ack = 1'b0;
    chk("R10 handshake finishes", dma_req, 0);
    seen = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      seen += int'(conv_req);
    end
    chk("R10 no requests", seen, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_settle();
    t_rates();
    t_settled_enable();
    t_vref_drop();
    t_flow();
    t_overrun_irq();
    t_page();
    t_disable();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1-all: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule